// File: doc/BRIEF.md
# Configurable Output Contact Logic Cell

This block is a single configurable output channel for a protection relay. Eight one-bit signal lines arrive from the relay functions. A per-line enable mask and a gate selector reduce them to one bit, and an optional inversion follows. A shaping stage then drives the contact bit. The shaping stage can pass the bit straight through, stretch a rising edge into a fixed pulse, hold it in a latch until it is cleared, or apply a pick-up delay and a drop-off delay. A bank of such cells makes up an output board. Each cell has its own configuration and counters.

All timing counts a one-millisecond strobe, `tick_ms`. Each timer setting is a whole number of strobes, from 0 to 300000, and is held in 19 bits. The configuration inputs are treated as static while a timer is running. The shaping stage is a state machine with the following states. In `ST_IDLE` the contact is released. In `ST_PASS_HI` the contact follows the input while it is high in pass mode. `ST_DWELL` is the active pulse. `ST_LATCHED` holds the flip-flop set. `ST_PICKUP` counts the on-delay with the contact still open. `ST_ON` is the steady closed state in delay mode. `ST_DROPOFF` counts the off-delay with the contact still closed.

The transitions are as follows:
- From `ST_IDLE`:
  - to `ST_PASS_HI` when the input is high in pass mode;
  - to `ST_DWELL` on a rising edge when the dwell time is not zero;
  - to `ST_LATCHED` when the input is high and no clear is present;
  - to `ST_PICKUP`, or straight to `ST_ON` when the on-delay is zero, when the input is high in delay mode.
- `ST_PICKUP` goes back to `ST_IDLE` when the input falls, or to `ST_ON` when the count completes.
- `ST_ON` goes to `ST_DROPOFF` when the input falls, or straight to `ST_IDLE` when the off-delay is zero.
- `ST_DROPOFF` goes back to `ST_ON` when the input rises, or to `ST_IDLE` when the count completes.
- `ST_DWELL` returns to `ST_IDLE` when its count completes.
- `ST_LATCHED` returns to `ST_IDLE` on a clear.
- `ST_PASS_HI` returns to `ST_IDLE` when the input falls.
- Any state that does not belong to the selected mode goes to `ST_IDLE`.

Top module: `outcell_channel`

## Requirements
- R1: When `cfg_gate_on` is 0, the shaping stage input is `sig_in[0]` alone. `en_mask`, `cfg_gate_sel` and `sig_in[7:1]` have no effect.
- R2: When `cfg_gate_on` is 1, `cfg_gate_sel` picks the gate over the lines whose `en_mask` bit is 1: 0 gives AND, 1 gives OR, 2 gives XOR (odd parity). Lines that are masked out have no effect. Code 3 gives 0. An all-zero mask gives 0 for every gate.
- R3: When `cfg_invert` is 1, the gate result is complemented before the shaping stage.
- R4: With `cfg_mode` = 0 (pass), `contact_out` equals the shaped bit as it stood at the previous clock edge.
- R5: With `cfg_mode` = 1 (dwell), a rising edge of the shaped bit closes the contact on the next edge. The contact opens at the edge of the `cfg_dwell_ms`-th tick. Edges during the pulse do not extend it. A high level with no new edge does not start a new pulse. A dwell setting of 0 gives no pulse.
- R6: With `cfg_mode` = 2 (latch), a high shaped bit sets the contact on the next edge. The contact stays set after the input falls and stays set through ticks, until `latch_clr` is high at an edge. `latch_clr` takes priority over a high input.
- R7: With `cfg_mode` = 3 (delay), the contact closes at the edge of the `cfg_on_ms`-th tick counted while the input stays high. A low excursion before that restarts the count. An on-delay of 0 closes the contact one cycle after the input rises.
- R8: In delay mode, the contact opens at the edge of the `cfg_off_ms`-th tick counted while the input stays low. A high excursion before that restarts the count. An off-delay of 0 opens the contact one cycle after the input falls.
- R9: While `rst_n` is low, `contact_out` is 0 whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle strobe every millisecond |
| sig_in | input | 8 | Signal lines, line 1 is bit 0 |
| en_mask | input | 8 | Per-line enable for the gate |
| cfg_gate_on | input | 1 | 0: bypass the gate, 1: use the gate |
| cfg_gate_sel | input | 2 | 0 AND, 1 OR, 2 XOR, 3 reserved |
| cfg_invert | input | 1 | Complement the gate result |
| cfg_mode | input | 2 | 0 pass, 1 dwell, 2 latch, 3 delay |
| cfg_on_ms | input | 19 | Pick-up delay in ticks |
| cfg_off_ms | input | 19 | Drop-off delay in ticks |
| cfg_dwell_ms | input | 19 | Pulse length in ticks |
| latch_clr | input | 1 | Clears the latch |
| contact_out | output | 1 | Contact drive bit |

## Verification
The gate is tried with several sets of patterns:
- Patterns that differ only in masked-out lines, which separate correct masking from a gate that reads every line.
- Patterns with one line cleared, which tell AND apart from OR.
- Patterns with two and three lines set, which tell XOR apart from OR.
- The bypass setting is driven with high upper lines and an empty mask, which shows that only line 1 is routed.

Each timed mode is checked one tick before its limit and at its limit. The bench then injects a one-cycle excursion part-way through the count. A design that keeps counting after the excursion opens or closes the contact early, while a design that restarts does not. In latch mode, clear and set are applied together to show that clear wins. In dwell mode, the bench drives a second edge during the pulse and holds the input high after the pulse ends.

// File: rtl/outcell_pkg.sv
package outcell_pkg;

    localparam int unsigned N_IN = 8;
    localparam int unsigned TW   = 19;

    typedef enum logic [1:0] {
        GATE_AND  = 2'd0,
        GATE_OR   = 2'd1,
        GATE_XOR  = 2'd2,
        GATE_RSVD = 2'd3
    } gate_e;

    typedef enum logic [1:0] {
        MODE_PASS  = 2'd0,
        MODE_DWELL = 2'd1,
        MODE_LATCH = 2'd2,
        MODE_DELAY = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PASS_HI = 3'd1,
        ST_DWELL   = 3'd2,
        ST_LATCHED = 3'd3,
        ST_PICKUP  = 3'd4,
        ST_ON      = 3'd5,
        ST_DROPOFF = 3'd6
    } state_e;

endpackage

// File: rtl/outcell_combiner.sv
module outcell_combiner
    import outcell_pkg::*;
#(
    parameter int unsigned NI = N_IN
) (
    input  logic [NI-1:0] sig_in,
    input  logic [NI-1:0] en_mask,
    input  logic          gate_on,
    input  logic [1:0]    gate_sel,
    input  logic          invert,
    output logic          shaped
);

    logic [NI-1:0] and_terms;
    logic [NI-1:0] sel_terms;
    logic          any_en;
    logic          r_and;
    logic          r_or;
    logic          r_xor;
    logic          gate_res;
    logic          src;
    gate_e         sel;

    // per-line conditioning: masked-out lines are neutral for each gate
    genvar gi;
    generate
        for (gi = 0; gi < NI; gi++) begin : g_line
            assign and_terms[gi] = ~en_mask[gi] | sig_in[gi];
            assign sel_terms[gi] =  en_mask[gi] & sig_in[gi];
        end
    endgenerate

    assign any_en = |en_mask;
    assign r_and  = any_en & (&and_terms);
    assign r_or   = |sel_terms;
    assign r_xor  = ^sel_terms;
    assign sel    = gate_e'(gate_sel);

    always_comb begin
        unique case (sel)
            GATE_AND:  gate_res = r_and;
            GATE_OR:   gate_res = r_or;
            GATE_XOR:  gate_res = r_xor;
            default:   gate_res = 1'b0;
        endcase
    end

    assign src    = gate_on ? gate_res : sig_in[0];
    assign shaped = src ^ invert;

    // an AND over a non-empty set implies the OR over the same set
    always_comb begin
        AST_AND_IMPLIES_OR: assert (!(r_and && !r_or)); // R2
    end

endmodule

// File: rtl/outcell_ms_counter.sv
module outcell_ms_counter
    import outcell_pkg::*;
#(
    parameter int unsigned W = TW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic         done
);

    localparam logic [W-1:0] CMAX = {W{1'b1}};

    logic [W:0] next_val;

    assign next_val = {1'b0, count} + {{W{1'b0}}, 1'b1};
    assign done     = tick && (next_val >= {1'b0, limit});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (tick && count != CMAX) begin
            count <= next_val[W-1:0];
        end
    end

endmodule

// File: rtl/outcell_shaper.sv
module outcell_shaper
    import outcell_pkg::*;
#(
    parameter int unsigned W = TW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         shaped,
    input  logic [1:0]   mode,
    input  logic [W-1:0] on_ms,
    input  logic [W-1:0] off_ms,
    input  logic [W-1:0] dwell_ms,
    input  logic         latch_clr,
    output logic         contact
);

    state_e       state_q;
    state_e       state_d;
    mode_e        mode_s;
    logic         prev_q;
    logic         rise;
    logic         cnt_clr;
    logic         cnt_done;
    logic [W-1:0] cnt;
    logic [W-1:0] limit;
    logic [1:0]   age_q;

    assign mode_s = mode_e'(mode);
    assign rise   = shaped & ~prev_q;

    // pick the limit for whichever timed state is active
    always_comb begin
        unique case (state_q)
            ST_DWELL:   limit = dwell_ms;
            ST_PICKUP:  limit = on_ms;
            ST_DROPOFF: limit = off_ms;
            default:    limit = '0;
        endcase
    end

    outcell_ms_counter #(.W(W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .tick  (tick),
        .limit (limit),
        .count (cnt),
        .done  (cnt_done)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                unique case (mode_s)
                    MODE_PASS:  if (shaped) state_d = ST_PASS_HI;
                    MODE_DWELL: if (rise && dwell_ms != '0) state_d = ST_DWELL;
                    MODE_LATCH: if (shaped && !latch_clr) state_d = ST_LATCHED;
                    MODE_DELAY: if (shaped) state_d = (on_ms == '0) ? ST_ON : ST_PICKUP;
                    default:    state_d = ST_IDLE;
                endcase
            end
            ST_PASS_HI: begin
                if (mode_s != MODE_PASS || !shaped) state_d = ST_IDLE;
            end
            ST_DWELL: begin
                if (mode_s != MODE_DWELL || cnt_done) state_d = ST_IDLE;
            end
            ST_LATCHED: begin
                if (mode_s != MODE_LATCH || latch_clr) state_d = ST_IDLE;
            end
            ST_PICKUP: begin
                if (mode_s != MODE_DELAY || !shaped) state_d = ST_IDLE;
                else if (cnt_done)                   state_d = ST_ON;
            end
            ST_ON: begin
                if (mode_s != MODE_DELAY)  state_d = ST_IDLE;
                else if (!shaped)          state_d = (off_ms == '0) ? ST_IDLE : ST_DROPOFF;
            end
            ST_DROPOFF: begin
                if (mode_s != MODE_DELAY)  state_d = ST_IDLE;
                else if (shaped)           state_d = ST_ON;
                else if (cnt_done)         state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // the counter restarts on every state change and idles outside timed states
    always_comb begin
        cnt_clr = (state_d != state_q) ||
                  !(state_q == ST_DWELL || state_q == ST_PICKUP || state_q == ST_DROPOFF);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            prev_q  <= 1'b0;
            age_q   <= 2'd0;
        end else begin
            state_q <= state_d;
            prev_q  <= shaped;
            if (age_q != 2'd3) age_q <= age_q + 2'd1;
        end
    end

    // output decode
    always_comb begin
        unique case (state_q)
            ST_PASS_HI, ST_DWELL, ST_LATCHED, ST_ON, ST_DROPOFF: contact = 1'b1;
            default:                                             contact = 1'b0;
        endcase
    end

    AST_PASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && mode == 2'd0 && $past(mode) == 2'd0 && $past(mode, 2) == 2'd0)
        |-> (contact == $past(shaped))); // R4

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DWELL && $stable(dwell_ms)) |-> (cnt < dwell_ms)); // R5

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0 && $past(state_q) == ST_LATCHED && !$past(latch_clr) && $past(mode) == 2'd2)
        |-> contact); // R6

    AST_LATCH_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0 && $past(latch_clr)) |-> (state_q != ST_LATCHED)); // R6

    AST_PICKUP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PICKUP && $stable(on_ms)) |-> (cnt < on_ms)); // R7

    AST_DELAY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0 && mode == 2'd3 && $past(mode) == 2'd3 && $rose(contact))
        |-> $past(shaped)); // R7

    AST_DROPOFF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DROPOFF && $stable(off_ms)) |-> (cnt < off_ms)); // R8

endmodule

// File: rtl/outcell_channel.sv
module outcell_channel
    import outcell_pkg::*;
#(
    parameter int unsigned NI = N_IN,
    parameter int unsigned W  = TW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_ms,
    input  logic [NI-1:0] sig_in,
    input  logic [NI-1:0] en_mask,
    input  logic          cfg_gate_on,
    input  logic [1:0]    cfg_gate_sel,
    input  logic          cfg_invert,
    input  logic [1:0]    cfg_mode,
    input  logic [W-1:0]  cfg_on_ms,
    input  logic [W-1:0]  cfg_off_ms,
    input  logic [W-1:0]  cfg_dwell_ms,
    input  logic          latch_clr,
    output logic          contact_out
);

    logic shaped;

    outcell_combiner #(.NI(NI)) u_comb (
        .sig_in   (sig_in),
        .en_mask  (en_mask),
        .gate_on  (cfg_gate_on),
        .gate_sel (cfg_gate_sel),
        .invert   (cfg_invert),
        .shaped   (shaped)
    );

    outcell_shaper #(.W(W)) u_shape (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_ms),
        .shaped    (shaped),
        .mode      (cfg_mode),
        .on_ms     (cfg_on_ms),
        .off_ms    (cfg_off_ms),
        .dwell_ms  (cfg_dwell_ms),
        .latch_clr (latch_clr),
        .contact   (contact_out)
    );

    AST_RESET_OPEN: assert property (@(posedge clk) !rst_n |-> !contact_out); // R9

endmodule

// File: tb/tb_outcell_channel.sv
module tb_outcell_channel;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_ms = 1'b0;
    logic [7:0]  sig_in = '0;
    logic [7:0]  en_mask = '0;
    logic        cfg_gate_on = 1'b0;
    logic [1:0]  cfg_gate_sel = 2'd0;
    logic        cfg_invert = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic [18:0] cfg_on_ms = '0;
    logic [18:0] cfg_off_ms = '0;
    logic [18:0] cfg_dwell_ms = '0;
    logic        latch_clr = 1'b0;
    logic        contact_out;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    outcell_channel dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_ms      (tick_ms),
        .sig_in       (sig_in),
        .en_mask      (en_mask),
        .cfg_gate_on  (cfg_gate_on),
        .cfg_gate_sel (cfg_gate_sel),
        .cfg_invert   (cfg_invert),
        .cfg_mode     (cfg_mode),
        .cfg_on_ms    (cfg_on_ms),
        .cfg_off_ms   (cfg_off_ms),
        .cfg_dwell_ms (cfg_dwell_ms),
        .latch_clr    (latch_clr),
        .contact_out  (contact_out)
    );

    task automatic chk(input logic exp, input string req, input string what);
        checks++;
        if (contact_out !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, contact_out, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick_pulse(input int n);
        for (int i = 0; i < n; i++) begin
            tick_ms = 1'b1;
            @(negedge clk);
            tick_ms = 1'b0;
        end
    endtask

    task automatic settle_low(input logic [1:0] mode);
        sig_in = '0; cfg_gate_on = 1'b0; cfg_invert = 1'b0; latch_clr = 1'b1;
        cfg_mode = mode;
        step(2);
        latch_clr = 1'b0;
        step(1);
    endtask

    task automatic t_reset;
        sig_in = 8'h01; cfg_mode = 2'd0;
        step(3);
        chk(1'b0, "R9", "contact while reset held with input high");
        rst_n = 1'b1;
        step(1);
        chk(1'b1, "R4", "pass after reset release");
    endtask

    task automatic t_bypass;
        settle_low(2'd0);
        cfg_gate_on = 1'b0; en_mask = 8'h00; cfg_gate_sel = 2'd0;
        sig_in = 8'h01; step(1);
        chk(1'b1, "R1", "bypass line1 high, empty mask");
        sig_in = 8'hFE; step(1);
        chk(1'b0, "R1", "bypass line1 low, upper lines high");
    endtask

    task automatic t_gates;
        settle_low(2'd0);
        cfg_gate_on = 1'b1;
        cfg_gate_sel = 2'd0; en_mask = 8'h0F;
        sig_in = 8'h0F; step(1); chk(1'b1, "R2", "AND all enabled high");
        sig_in = 8'h8F; step(1); chk(1'b1, "R2", "AND masked line ignored");
        sig_in = 8'hF7; step(1); chk(1'b0, "R2", "AND one enabled low");
        cfg_gate_sel = 2'd1; en_mask = 8'h30;
        sig_in = 8'h10; step(1); chk(1'b1, "R2", "OR one enabled high");
        sig_in = 8'hCF; step(1); chk(1'b0, "R2", "OR only masked lines high");
        cfg_gate_sel = 2'd2; en_mask = 8'hFF;
        sig_in = 8'h07; step(1); chk(1'b1, "R2", "XOR three high");
        sig_in = 8'h03; step(1); chk(1'b0, "R2", "XOR two high");
        cfg_gate_sel = 2'd3; sig_in = 8'hFF; step(1);
        chk(1'b0, "R2", "reserved gate code");
        en_mask = 8'h00; sig_in = 8'hFF;
        cfg_gate_sel = 2'd0; step(1); chk(1'b0, "R2", "AND empty mask");
        cfg_gate_sel = 2'd1; step(1); chk(1'b0, "R2", "OR empty mask");
        cfg_gate_sel = 2'd2; step(1); chk(1'b0, "R2", "XOR empty mask");
        cfg_gate_on = 1'b0;
    endtask

    task automatic t_invert;
        settle_low(2'd0);
        cfg_invert = 1'b1; sig_in = 8'h00; step(1);
        chk(1'b1, "R3", "inverted low input");
        sig_in = 8'h01; step(1);
        chk(1'b0, "R3", "inverted high input");
        cfg_invert = 1'b0;
    endtask

    task automatic t_pass_latency;
        settle_low(2'd0);
        sig_in = 8'h01; #1;
        chk(1'b0, "R4", "no change before clock edge");
        step(1);
        chk(1'b1, "R4", "follows after one edge");
        sig_in = 8'h00; step(1);
        chk(1'b0, "R4", "falls after one edge");
    endtask

    task automatic t_dwell;
        settle_low(2'd1);
        cfg_dwell_ms = 19'd4;
        sig_in = 8'h01; step(1);
        chk(1'b1, "R5", "pulse starts on rising edge");
        tick_pulse(1);
        sig_in = 8'h00; step(1);
        sig_in = 8'h01; step(1);
        tick_pulse(2);
        chk(1'b1, "R5", "still high after 3 ticks with retrigger");
        tick_pulse(1);
        chk(1'b0, "R5", "released at 4th tick, not extended");
        step(3);
        chk(1'b0, "R5", "held level gives no new pulse");
        cfg_dwell_ms = 19'd0;
        sig_in = 8'h00; step(1);
        sig_in = 8'h01; step(1);
        chk(1'b0, "R5", "zero dwell gives no pulse");
    endtask

    task automatic t_latch;
        settle_low(2'd2);
        sig_in = 8'h01; step(1);
        chk(1'b1, "R6", "latch set");
        sig_in = 8'h00; step(3); tick_pulse(5);
        chk(1'b1, "R6", "latch holds after input falls");
        latch_clr = 1'b1; step(1);
        chk(1'b0, "R6", "latch cleared");
        latch_clr = 1'b0; step(1);
        chk(1'b0, "R6", "stays clear with input low");
        latch_clr = 1'b1; sig_in = 8'h01; step(2);
        chk(1'b0, "R6", "clear wins over high input");
        latch_clr = 1'b0; step(1);
        chk(1'b1, "R6", "sets once clear released");
        latch_clr = 1'b1; sig_in = 8'h00; step(1);
        latch_clr = 1'b0;
    endtask

    task automatic t_pickup;
        settle_low(2'd3);
        cfg_on_ms = 19'd3; cfg_off_ms = 19'd0;
        sig_in = 8'h01; step(1);
        chk(1'b0, "R7", "open at start of pickup");
        tick_pulse(2);
        chk(1'b0, "R7", "open after 2 ticks");
        sig_in = 8'h00; step(1);
        sig_in = 8'h01; step(1);
        tick_pulse(2);
        chk(1'b0, "R7", "restarted count, open after 2 more ticks");
        tick_pulse(1);
        chk(1'b1, "R7", "closed at 3rd tick");
        sig_in = 8'h00; step(1);
        chk(1'b0, "R8", "zero off-delay opens next cycle");
        cfg_on_ms = 19'd0;
        sig_in = 8'h01; step(1);
        chk(1'b1, "R7", "zero on-delay closes next cycle");
        sig_in = 8'h00; step(1);
    endtask

    task automatic t_dropoff;
        settle_low(2'd3);
        cfg_on_ms = 19'd0; cfg_off_ms = 19'd3;
        sig_in = 8'h01; step(1);
        sig_in = 8'h00; step(1);
        chk(1'b1, "R8", "closed at start of dropoff");
        tick_pulse(2);
        chk(1'b1, "R8", "closed after 2 low ticks");
        sig_in = 8'h01; step(1);
        sig_in = 8'h00; step(1);
        tick_pulse(2);
        chk(1'b1, "R8", "restarted count, closed after 2 more ticks");
        tick_pulse(1);
        chk(1'b0, "R8", "opened at 3rd tick");
    endtask

    initial begin
        t_reset();
        t_bypass();
        t_gates();
        t_invert();
        t_pass_latency();
        t_dwell();
        t_latch();
        t_pickup();
        t_dropoff();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule